// File: doc/BRIEF.md
# Hardwired Timing and Interrupt Sequencer

This block is the timing and control core of a 16-bit machine built around a single accumulator. A 4-bit step counter is decoded into sixteen one-hot timing strobes. The opcode field of the current instruction word is decoded into eight one-hot group lines, and the addressing-mode bit is captured in its own flip-flop. From these the block emits one-cycle enable pulses for the datapath registers and memory. The datapath, memory and ALU sit outside the block and only receive these pulses.

One step counter drives two paths. With the interrupt request flip-flop clear, steps 0 to 3 issue the instruction fetch, the decode, the optional indirect read and the choice of execute group. With the request set, steps 0 to 2 run a hardware call: the return address is saved at memory word 0, the program counter is redirected to 1, and the sequence starts again. The request can only be set outside the first three steps, so a fetch that has started always completes. The execute logic ends an instruction by pulsing an external clear-counter request. A halt sub-instruction stops the sequencer until the next reset.

Top module: `seq_core`

## Requirements
- R1: While running, exactly one bit of `timeStep` is high, namely bit `stepCount`. While stopped, `timeStep` is all zero.
- R2: While running and with no clear pending, `stepCount` advances by one on every rising edge and wraps from 15 to 0.
- R3: A `seqClear` pulse takes priority over the increment, so the step after the pulse is T0. For example, a clear at T4 gives T0 and not T5.
- R4: Synchronous reset clears the counter, so T0 is active once reset drops. Reset also leaves `running`=1, `intReq`=0 and `indirectBit`=0.
- R5: `opDecode` is one-hot and selects bit `instrWord[14:12]`. `indirectBit` captures `instrWord[15]` at the edge that ends fetch step T2.
- R6: `intReq` is set at an edge where T0, T1 and T2 are all inactive, `intEnable`=1, `running`=1, and `inReady` or `outReady` is 1. It is never set at the edge that ends T0, T1 or T2.
- R7: With `intReq`=0, fetch issues `arFromPc` at T0, `irLoad` and `pcInc` at T1, and `arFromIr` at T2.
- R8: At T3 with `intReq`=0, exactly one of these applies. With opcode 7 and `indirectBit`=0, `regRefExec` is issued. With opcode 7 and `indirectBit`=1, `ioExec` is issued. With any other opcode and `indirectBit`=1, `arFromMem` is issued. Otherwise none of the three is issued.
- R9: With `intReq`=1, the block issues `arClear` and `trFromPc` at T0, `memWriteTr` and `pcClear` at T1, and `pcInc` and `ienClear` at T2. The edge that ends that T2 clears `intReq` and returns the counter to T0. No fetch strobe is issued during these steps.
- R10: A register-reference step (`regRefExec`) with `instrWord[0]`=1 halts the block. From the next edge until reset, `running`=0, `stepCount`=0, and all strobes and timing lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | 16 | Current instruction register word |
| intEnable | input | 1 | Interrupt enable flag from the datapath |
| inReady | input | 1 | Input-ready flag |
| outReady | input | 1 | Output-ready flag |
| seqClear | input | 1 | Clear-counter request from the execute logic |
| stepCount | output | 4 | Current step number |
| timeStep | output | 16 | One-hot timing strobes T0..T15 |
| opDecode | output | 8 | One-hot opcode group lines |
| indirectBit | output | 1 | Captured addressing-mode bit |
| intReq | output | 1 | Interrupt request flip-flop |
| running | output | 1 | Start-stop flip-flop |
| arFromPc | output | 1 | Load address register from PC |
| irLoad | output | 1 | Load instruction register from memory |
| pcInc | output | 1 | Increment PC |
| arFromIr | output | 1 | Load address register from the address field |
| arFromMem | output | 1 | Load address register from memory (indirect) |
| regRefExec | output | 1 | Register-reference execute step |
| ioExec | output | 1 | Input-output execute step |
| arClear | output | 1 | Clear address register |
| trFromPc | output | 1 | Copy PC into the temporary register |
| memWriteTr | output | 1 | Write the temporary register to memory |
| pcClear | output | 1 | Clear PC |
| ienClear | output | 1 | Clear interrupt enable |

## Verification
The bench walks the counter through a full lap and past the wrap. A design that saturated or skipped a step at 15 would break the expected step sequence. It clears the counter at T4 under opcode 3, which catches a design that lets the increment win and steps to T5. Every opcode and mode-bit combination is driven to T3, so a swapped indirect/IO selection or a badly decoded opcode group shows up as a wrong strobe. The interrupt request is raised at T0 and sampled at each step; a design that sets it inside the T0..T2 window shows `intReq` high at T1 or T2. The interrupt cycle's strobes and its exit are checked, and finally a halt is checked to freeze all timing lines.

// File: rtl/seq_pkg.sv
package seq_pkg;

  // Pulses that leave the block toward datapath registers and memory.
  typedef struct packed {
    logic arFromPc;
    logic irLoad;
    logic pcInc;
    logic arFromIr;
    logic arFromMem;
    logic regRefExec;
    logic ioExec;
    logic arClear;
    logic trFromPc;
    logic memWriteTr;
    logic pcClear;
    logic ienClear;
  } busStrobes_t;

  // Pulses that steer the sequencer's own state.
  typedef struct packed {
    logic clrCount;
    logic latchMode;
    logic setReq;
    logic dropReq;
    logic stopRun;
  } coreStrobes_t;

  typedef struct packed {
    busStrobes_t  bus;
    coreStrobes_t core;
  } ctrlStrobes_t;

endpackage

// File: rtl/seq_onehot_dec.sv
module seq_onehot_dec #(
  parameter int IN_W  = 4,
  parameter int OUT_N = 2 ** IN_W
) (
  input  logic             en,
  input  logic [IN_W-1:0]  code,
  output logic [OUT_N-1:0] hot
);
  for (genvar k = 0; k < OUT_N; k++) begin : g_line
    assign hot[k] = en && (code == IN_W'(k));
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int OP_W   = 3,
  localparam int STEPS = 2 ** STEP_W,
  localparam int OPS   = 2 ** OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              modeIn,
  input  logic [OP_W-1:0]   opIn,
  input  logic              seqClearExt,
  input  ctrlStrobes_t      ctrl,
  output logic [STEP_W-1:0] stepCount,
  output logic [STEPS-1:0]  timeStep,
  output logic [OPS-1:0]    opDecode,
  output logic              modeBit,
  output logic              reqFlag,
  output logic              runFlag
);

  // Step counter: clear wins over increment; holds while stopped.
  always_ff @(posedge clk) begin
    if (rst) begin
      stepCount <= '0;
    end else if (seqClearExt || ctrl.core.clrCount) begin
      stepCount <= '0;
    end else if (runFlag) begin
      stepCount <= stepCount + 1'b1;
    end
  end

  // Start-stop flip-flop.
  always_ff @(posedge clk) begin
    if (rst) begin
      runFlag <= 1'b1;
    end else if (ctrl.core.stopRun) begin
      runFlag <= 1'b0;
    end
  end

  // Interrupt request flip-flop; the drop only happens at interrupt T2,
  // where a set is never requested.
  always_ff @(posedge clk) begin
    if (rst) begin
      reqFlag <= 1'b0;
    end else if (ctrl.core.dropReq) begin
      reqFlag <= 1'b0;
    end else if (ctrl.core.setReq) begin
      reqFlag <= 1'b1;
    end
  end

  // Addressing-mode flip-flop, captured during decode.
  always_ff @(posedge clk) begin
    if (rst) begin
      modeBit <= 1'b0;
    end else if (ctrl.core.latchMode) begin
      modeBit <= modeIn;
    end
  end

  seq_onehot_dec #(.IN_W(STEP_W)) u_stepDec (
    .en  (runFlag),
    .code(stepCount),
    .hot (timeStep)
  );

  seq_onehot_dec #(.IN_W(OP_W)) u_opDec (
    .en  (1'b1),
    .code(opIn),
    .hot (opDecode)
  );

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int OP_W   = 3,
  localparam int STEPS = 2 ** STEP_W,
  localparam int OPS   = 2 ** OP_W,
  localparam int GRP   = OPS - 1
) (
  input  logic [STEPS-1:0] timeStep,
  input  logic [OPS-1:0]   opDecode,
  input  logic             modeBit,
  input  logic             reqFlag,
  input  logic             runFlag,
  input  logic             haltBit,
  input  logic             intEnable,
  input  logic             inReady,
  input  logic             outReady,
  output ctrlStrobes_t     ctrl
);

  logic t0, t1, t2, t3;
  logic normal, irq, execGrp, haltNow;

  assign t0 = timeStep[0];
  assign t1 = timeStep[1];
  assign t2 = timeStep[2];
  assign t3 = timeStep[3];

  assign normal  = !reqFlag;
  assign irq     = reqFlag;
  assign execGrp = opDecode[GRP];
  assign haltNow = normal && t3 && execGrp && !modeBit && haltBit;

  always_comb begin
    ctrl = '0;
    // Fetch and decode path.
    ctrl.bus.arFromPc   = normal && t0;
    ctrl.bus.irLoad     = normal && t1;
    ctrl.bus.arFromIr   = normal && t2;
    ctrl.bus.arFromMem  = normal && t3 && !execGrp && modeBit;
    ctrl.bus.regRefExec = normal && t3 && execGrp && !modeBit;
    ctrl.bus.ioExec     = normal && t3 && execGrp && modeBit;
    // Interrupt path.
    ctrl.bus.arClear    = irq && t0;
    ctrl.bus.trFromPc   = irq && t0;
    ctrl.bus.memWriteTr = irq && t1;
    ctrl.bus.pcClear    = irq && t1;
    ctrl.bus.ienClear   = irq && t2;
    ctrl.bus.pcInc      = (normal && t1) || (irq && t2);
    // Own state.
    ctrl.core.latchMode = normal && t2;
    ctrl.core.dropReq   = irq && t2;
    ctrl.core.setReq    = runFlag && !(t0 || t1 || t2) && intEnable
                          && (inReady || outReady);
    ctrl.core.stopRun   = haltNow;
    ctrl.core.clrCount  = (irq && t2) || haltNow;
  end

endmodule

// File: rtl/seq_core.sv
module seq_core
  import seq_pkg::*;
#(
  parameter int STEP_W = 4,
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  localparam int STEPS = 2 ** STEP_W,
  localparam int OPS   = 2 ** OP_W,
  localparam int MODE_POS = WORD_W - 1,
  localparam int OP_LSB   = WORD_W - 1 - OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              intEnable,
  input  logic              inReady,
  input  logic              outReady,
  input  logic              seqClear,
  output logic [STEP_W-1:0] stepCount,
  output logic [STEPS-1:0]  timeStep,
  output logic [OPS-1:0]    opDecode,
  output logic              indirectBit,
  output logic              intReq,
  output logic              running,
  output logic              arFromPc,
  output logic              irLoad,
  output logic              pcInc,
  output logic              arFromIr,
  output logic              arFromMem,
  output logic              regRefExec,
  output logic              ioExec,
  output logic              arClear,
  output logic              trFromPc,
  output logic              memWriteTr,
  output logic              pcClear,
  output logic              ienClear
);

  ctrlStrobes_t ctrl;
  wire unusedAddrBits = ^instrWord[OP_LSB-1:1];

  seq_datapath #(.STEP_W(STEP_W), .OP_W(OP_W)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .modeIn     (instrWord[MODE_POS]),
    .opIn       (instrWord[MODE_POS-1:OP_LSB]),
    .seqClearExt(seqClear),
    .ctrl       (ctrl),
    .stepCount  (stepCount),
    .timeStep   (timeStep),
    .opDecode   (opDecode),
    .modeBit    (indirectBit),
    .reqFlag    (intReq),
    .runFlag    (running)
  );

  seq_ctrl #(.STEP_W(STEP_W), .OP_W(OP_W)) u_ctrl (
    .timeStep (timeStep),
    .opDecode (opDecode),
    .modeBit  (indirectBit),
    .reqFlag  (intReq),
    .runFlag  (running),
    .haltBit  (instrWord[0]),
    .intEnable(intEnable),
    .inReady  (inReady),
    .outReady (outReady),
    .ctrl     (ctrl)
  );

  assign arFromPc   = ctrl.bus.arFromPc;
  assign irLoad     = ctrl.bus.irLoad;
  assign pcInc      = ctrl.bus.pcInc;
  assign arFromIr   = ctrl.bus.arFromIr;
  assign arFromMem  = ctrl.bus.arFromMem;
  assign regRefExec = ctrl.bus.regRefExec;
  assign ioExec     = ctrl.bus.ioExec;
  assign arClear    = ctrl.bus.arClear;
  assign trFromPc   = ctrl.bus.trFromPc;
  assign memWriteTr = ctrl.bus.memWriteTr;
  assign pcClear    = ctrl.bus.pcClear;
  assign ienClear   = ctrl.bus.ienClear;

endmodule

// File: rtl/seq_core_chk.sv
module seq_core_chk #(
  parameter int STEP_W = 4,
  parameter int WORD_W = 16,
  parameter int OP_W   = 3,
  localparam int STEPS = 2 ** STEP_W,
  localparam int OPS   = 2 ** OP_W
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] instrWord,
  input logic              seqClear,
  input logic [STEP_W-1:0] stepCount,
  input logic [STEPS-1:0]  timeStep,
  input logic [OPS-1:0]    opDecode,
  input logic              indirectBit,
  input logic              intReq,
  input logic              running,
  input logic              arFromPc,
  input logic              arFromMem,
  input logic              regRefExec,
  input logic              ioExec
);

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    running |-> ($countones(timeStep) == 1)); // R1

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    !running |-> (timeStep == '0)); // R10

  AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    running && !seqClear && !intReq && !(regRefExec && instrWord[0])
    |=> stepCount == STEP_W'($past(stepCount) + 1'b1)); // R2

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    seqClear |=> (stepCount == '0)); // R3

  AST_OP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(opDecode) == 1); // R5

  AST_MODE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    !intReq && timeStep[2] |=> indirectBit == $past(instrWord[WORD_W-1])); // R5

  AST_REQ_WINDOW: assert property (@(posedge clk) disable iff (rst)
    !intReq && (timeStep[0] || timeStep[1] || timeStep[2]) |=> !intReq); // R6

  AST_NO_FETCH_IN_IRQ: assert property (@(posedge clk) disable iff (rst)
    intReq |-> !arFromPc); // R9

  AST_T3_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({arFromMem, regRefExec, ioExec})); // R8

  AST_IRQ_EXIT: assert property (@(posedge clk) disable iff (rst)
    intReq && timeStep[2] |=> !intReq && (stepCount == '0)); // R9

  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (rst)
    regRefExec && instrWord[0] |=> !running && (stepCount == '0)); // R10

endmodule

bind seq_core seq_core_chk #(.STEP_W(STEP_W), .WORD_W(WORD_W), .OP_W(OP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instrWord  (instrWord),
  .seqClear   (seqClear),
  .stepCount  (stepCount),
  .timeStep   (timeStep),
  .opDecode   (opDecode),
  .indirectBit(indirectBit),
  .intReq     (intReq),
  .running    (running),
  .arFromPc   (arFromPc),
  .arFromMem  (arFromMem),
  .regRefExec (regRefExec),
  .ioExec     (ioExec)
);

// File: tb/seq_core_test.sv
`timescale 1ns/1ps
module seq_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instrWord = '0;
  logic        intEnable = 1'b0;
  logic        inReady = 1'b0;
  logic        outReady = 1'b0;
  logic        seqClear = 1'b0;
  logic [3:0]  stepCount;
  logic [15:0] timeStep;
  logic [7:0]  opDecode;
  logic indirectBit, intReq, running;
  logic arFromPc, irLoad, pcInc, arFromIr, arFromMem, regRefExec, ioExec;
  logic arClear, trFromPc, memWriteTr, pcClear, ienClear;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seq_core uut (
    .clk(clk), .rst(rst), .instrWord(instrWord), .intEnable(intEnable),
    .inReady(inReady), .outReady(outReady), .seqClear(seqClear),
    .stepCount(stepCount), .timeStep(timeStep), .opDecode(opDecode),
    .indirectBit(indirectBit), .intReq(intReq), .running(running),
    .arFromPc(arFromPc), .irLoad(irLoad), .pcInc(pcInc), .arFromIr(arFromIr),
    .arFromMem(arFromMem), .regRefExec(regRefExec), .ioExec(ioExec),
    .arClear(arClear), .trFromPc(trFromPc), .memWriteTr(memWriteTr),
    .pcClear(pcClear), .ienClear(ienClear)
  );

  wire [11:0] gotStr = {arFromPc, irLoad, pcInc, arFromIr, arFromMem, regRefExec,
                        ioExec, arClear, trFromPc, memWriteTr, pcClear, ienClear};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic clearToT0();
    seqClear = 1'b1;
    tick();
    seqClear = 1'b0;
  endtask

  function automatic logic [11:0] expStr(int s, bit r, bit ib, int op);
    bit t0, t1, t2, t3, grp;
    t0 = (s == 0); t1 = (s == 1); t2 = (s == 2); t3 = (s == 3);
    grp = (op == 7);
    return {!r && t0, !r && t1, (!r && t1) || (r && t2), !r && t2,
            !r && t3 && !grp && ib, !r && t3 && grp && !ib, !r && t3 && grp && ib,
            r && t0, r && t0, r && t1, r && t1, r && t2};
  endfunction

  task automatic checkStep(input int e, input string req);
    check(stepCount == 4'(e), req, "stepCount", stepCount, e);
    check(timeStep == 16'(1 << e), "R1", "timeStep", timeStep, 1 << e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    // R4: reset state
    check(stepCount == 0 && timeStep == 16'h1, "R4", "step after reset", timeStep, 1);
    check(running == 1'b1, "R4", "running", running, 1);
    check(intReq == 1'b0, "R4", "intReq", intReq, 0);
    check(indirectBit == 1'b0, "R4", "indirectBit", indirectBit, 0);

    // R2 R7: free run over a full lap and past the wrap, opcode 0 direct
    for (int k = 0; k < 20; k++) begin
      checkStep(k % 16, "R2");
      check(gotStr == expStr(k % 16, 0, 0, 0), "R7", "fetch strobes", gotStr,
            expStr(k % 16, 0, 0, 0));
      tick();
    end

    // R3: clear at T4 under opcode 3 gives T0, not T5
    instrWord = 16'h3123;
    clearToT0();
    check(opDecode == 8'h08, "R5", "opDecode op3", opDecode, 8'h08);
    for (int k = 0; k < 6; k++) begin
      checkStep((k == 5) ? 0 : k, "R3");
      if (k == 4) seqClear = 1'b1;
      tick();
      seqClear = 1'b0;
    end

    // R5 R8: every opcode with both mode bits, checked at T3
    for (int op = 0; op < 8; op++) begin
      for (int ib = 0; ib < 2; ib++) begin
        instrWord = {ib[0], op[2:0], 12'h010};
        clearToT0();
        tick(); tick(); tick();
        checkStep(3, "R8");
        check(opDecode == 8'(1 << op), "R5", "opDecode", opDecode, 1 << op);
        check(indirectBit == ib[0], "R5", "indirectBit", indirectBit, ib);
        check(gotStr == expStr(3, 0, ib[0], op), "R8", "T3 strobes", gotStr,
              expStr(3, 0, ib[0], op));
      end
    end

    // R6: enable off keeps the request low
    instrWord = 16'h0000;
    clearToT0();
    inReady = 1'b1;
    for (int k = 0; k < 6; k++) tick();
    check(intReq == 1'b0, "R6", "intReq with enable off", intReq, 0);
    inReady = 1'b0;

    // R6 R9: request raised from T0, once by each flag
    for (int f = 0; f < 2; f++) begin
      clearToT0();
      intEnable = 1'b1;
      inReady = (f == 0);
      outReady = (f == 1);
      for (int k = 1; k < 5; k++) begin
        tick();
        check(intReq == (k == 4), "R6", "intReq at step", intReq, (k == 4));
      end
      seqClear = 1'b1;
      tick();
      seqClear = 1'b0;
      for (int s = 0; s < 3; s++) begin
        checkStep(s, "R9");
        check(gotStr == expStr(s, 1, indirectBit, 0), "R9", "irq strobes", gotStr,
              expStr(s, 1, indirectBit, 0));
        if (s == 2) begin
          intEnable = 1'b0;
          inReady = 1'b0;
          outReady = 1'b0;
        end
        tick();
      end
      check(intReq == 1'b0, "R9", "intReq after irq cycle", intReq, 0);
      checkStep(0, "R9");
      check(arFromPc == 1'b1, "R9", "fetch resumes", arFromPc, 1);
    end

    // R10: halt
    instrWord = 16'h7001;
    clearToT0();
    tick(); tick(); tick();
    check(regRefExec == 1'b1, "R10", "regRefExec before halt", regRefExec, 1);
    for (int k = 0; k < 4; k++) begin
      tick();
      check(running == 1'b0, "R10", "running", running, 0);
      check(stepCount == 0 && timeStep == 0, "R10", "timeStep", timeStep, 0);
      check(gotStr == 12'h000, "R10", "strobes", gotStr, 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule